// File: doc/BRIEF.md
# Width-adaptive flit lane mapper

This block sits between a link layer that works in 80-bit flow-control units (flits) and a 20-lane point-to-point physical link. On the send side it cuts each flit into per-edge lane words of 20, 10 or 5 bits, depending on how many lanes are usable, and drives them onto the proper group of lanes with a marker on the first word of each flit. On the receive side it does the reverse: it gathers the lane words back into whole flits.

The usable width follows a four-bit mask that marks which five-lane quadrants are healthy. The mapper falls back from full width to half width (two adjacent quadrants) or quarter width (one quadrant). It goes idle when no quadrant is usable. A width change only takes effect between flits. On the receive side, a short training exchange lets the block find out by itself whether the board wiring has the lanes in reverse order and which lanes have their polarity swapped. From then on it undoes both in every received word.

Top module: `flit_lane_mapper`

## Requirements
- R1: A flit is sent as 4 words at full width (20 bits each), 8 at half width (10 bits) or 16 at quarter width (5 bits), on consecutive cycles, least-significant slice first (word k carries flit bits k*W up to k*W+W-1), starting the cycle after the flit is accepted.
- R2: The send side raises tx_lane_vld for every word and tx_start only on the first word of a flit. It drives zero on every lane outside the active group and on all lanes while idle; after reset no word is sent.
- R3: Width choice from quad_ok (bit q covers lanes 5q..5q+4): all four set gives full width on lanes 0-19; otherwise bits 0 and 1 both set gives half width on lanes 0-9; otherwise bits 2 and 3 both set gives half width on lanes 10-19; otherwise the lowest set bit q gives quarter width on lanes 5q..5q+4; no bit set gives idle, where tx_ready is low and nothing is sent.
- R4: A change of quad_ok while a flit is being sent does not alter that flit; the next flit uses the new width.
- R5: A receive word with rx_start and rx_valid high opens a flit. When the last word for the current width arrives, the whole flit appears on rx_flit, with rx_flit_vld high for one cycle in the next cycle. Receive slices are read from the same lanes and in the same order as on the send side.
- R6: A partly gathered flit is dropped, and never delivered, when a new rx_start arrives or when the active width changes before it is complete.
- R7: Training (rx_train high) is a series of word pairs: a reference word of all zeros with rx_start high, then the 20-bit training pattern. A lane that reads 1 in the reference word is marked inverted. After polarity correction, the pattern is matched in direct order and in reversed order (lane p taken from lane 19-p). After TRAIN_REPS consecutive matching pairs that agree on polarity and order, both settings are adopted.
- R8: Every received data word is corrected by flipping the inverted lanes and then, if reversal was found, mirroring lane p to 19-p, before its slice is taken.
- R9: Polarity and order settings stay unchanged outside training, after a training run shorter than TRAIN_REPS pairs, and after pairs whose pattern matches in neither order.
- R10: Receive cycles with rx_valid low are ignored, whatever rx_lanes and rx_start carry, and do not break a flit in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quad_ok | input | 4 | Health mask, one bit per five-lane quadrant |
| tx_flit | input | 80 | Flit to send |
| tx_valid | input | 1 | tx_flit is valid |
| tx_ready | output | 1 | Send side can accept a flit this cycle |
| tx_lanes | output | 20 | Lane word driven onto the link |
| tx_start | output | 1 | First word of a flit |
| tx_lane_vld | output | 1 | tx_lanes carries a word this cycle |
| rx_lanes | input | 20 | Lane word received from the link |
| rx_valid | input | 1 | rx_lanes carries a word |
| rx_start | input | 1 | First word of a flit, or reference word in training |
| rx_train | input | 1 | Link is in training |
| rx_flit | output | 80 | Reassembled flit |
| rx_flit_vld | output | 1 | rx_flit is valid this cycle |

## Verification
The checks assume that rx_start only marks the first word of a flit and that training words come in strict reference-then-pattern pairs. They also assume that the training pattern is not its own mirror image, so the two lane orders can never both match. The bench changes quad_ok only between clock edges, and waits a few cycles after each change before it sends receive traffic, so that the receive side has taken up the new width. It drives training with the same wiring model it uses for data, including deliberately corrupted and too-short runs.

// File: rtl/flm_pkg.sv
package flm_pkg;
  localparam int FLIT_W   = 80;
  localparam int LANES    = 20;
  localparam int QUADS    = 4;
  localparam int QW       = LANES / QUADS;
  localparam int MAX_XFER = FLIT_W / QW;
  localparam int CNT_W    = $clog2(MAX_XFER);

  typedef enum logic [1:0] {
    WM_IDLE    = 2'd0,
    WM_QUARTER = 2'd1,
    WM_HALF    = 2'd2,
    WM_FULL    = 2'd3
  } wmode_e;

  // index of the final transfer of a flit for a given width
  function automatic logic [CNT_W-1:0] xfer_last(input wmode_e m);
    case (m)
      WM_FULL: return CNT_W'(FLIT_W / LANES - 1);
      WM_HALF: return CNT_W'(FLIT_W / (2 * QW) - 1);
      default: return CNT_W'(FLIT_W / QW - 1);
    endcase
  endfunction

  function automatic logic [LANES-1:0] flip_lanes(input logic [LANES-1:0] w);
    logic [LANES-1:0] r;
    for (int i = 0; i < LANES; i++) r[i] = w[LANES-1-i];
    return r;
  endfunction

  // slice k of a flit, right-aligned
  function automatic logic [LANES-1:0] get_slice(input logic [FLIT_W-1:0] f,
                                                 input wmode_e m,
                                                 input logic [CNT_W-1:0] k);
    logic [LANES-1:0] s;
    s = '0;
    case (m)
      WM_FULL:    s = f[k[1:0]*LANES +: LANES];
      WM_HALF:    s[2*QW-1:0] = f[k[2:0]*(2*QW) +: 2*QW];
      WM_QUARTER: s[QW-1:0] = f[k*QW +: QW];
      default:    s = '0;
    endcase
    return s;
  endfunction

  // write slice k into a flit image
  function automatic logic [FLIT_W-1:0] put_slice(input logic [FLIT_W-1:0] f,
                                                  input logic [LANES-1:0] s,
                                                  input wmode_e m,
                                                  input logic [CNT_W-1:0] k);
    logic [FLIT_W-1:0] r;
    r = f;
    case (m)
      WM_FULL:    r[k[1:0]*LANES +: LANES] = s;
      WM_HALF:    r[k[2:0]*(2*QW) +: 2*QW] = s[2*QW-1:0];
      WM_QUARTER: r[k*QW +: QW] = s[QW-1:0];
      default:    r = f;
    endcase
    return r;
  endfunction

  // place a right-aligned slice onto the active lane group
  function automatic logic [LANES-1:0] place_slice(input logic [LANES-1:0] s,
                                                   input wmode_e m,
                                                   input logic [1:0] q);
    logic [LANES-1:0] w;
    w = '0;
    case (m)
      WM_FULL: w = s;
      WM_HALF: begin
        if (q[1]) w[LANES-1:2*QW] = s[2*QW-1:0];
        else      w[2*QW-1:0]     = s[2*QW-1:0];
      end
      WM_QUARTER: w[q*QW +: QW] = s[QW-1:0];
      default: w = '0;
    endcase
    return w;
  endfunction

  // pull the active lane group out of a lane word, right-aligned
  function automatic logic [LANES-1:0] take_slice(input logic [LANES-1:0] w,
                                                  input wmode_e m,
                                                  input logic [1:0] q);
    logic [LANES-1:0] s;
    s = '0;
    case (m)
      WM_FULL: s = w;
      WM_HALF: s[2*QW-1:0] = q[1] ? w[LANES-1:2*QW] : w[2*QW-1:0];
      WM_QUARTER: s[QW-1:0] = w[q*QW +: QW];
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/flm_width_sel.sv
module flm_width_sel
  import flm_pkg::*;
(
  input  logic [QUADS-1:0] quad_ok,
  output wmode_e           mode,
  output logic [1:0]       base
);
  always_comb begin
    mode = WM_IDLE;
    base = 2'd0;
    if (&quad_ok) begin
      mode = WM_FULL;
    end else if (quad_ok[0] && quad_ok[1]) begin
      mode = WM_HALF;
    end else if (quad_ok[2] && quad_ok[3]) begin
      mode = WM_HALF;
      base = 2'd2;
    end else if (|quad_ok) begin
      mode = WM_QUARTER;
      // lowest healthy quadrant wins
      for (int i = QUADS - 1; i >= 0; i--) begin
        if (quad_ok[i]) base = 2'(i);
      end
    end
  end
endmodule

// File: rtl/flm_tx_serdes.sv
module flm_tx_serdes
  import flm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wmode_e            sel_mode,
  input  logic [1:0]        sel_base,
  input  logic [FLIT_W-1:0] tx_flit,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [LANES-1:0]  tx_lanes,
  output logic              tx_start,
  output logic              tx_lane_vld,
  output wmode_e            act_mode,
  output logic [1:0]        act_base
);
  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [FLIT_W-1:0] flit_q;
  logic              take;

  assign tx_ready = !busy && (sel_mode != WM_IDLE);
  assign take     = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      cnt         <= '0;
      flit_q      <= '0;
      act_mode    <= WM_IDLE;
      act_base    <= 2'd0;
      tx_lanes    <= '0;
      tx_start    <= 1'b0;
      tx_lane_vld <= 1'b0;
    end else begin
      tx_lanes    <= '0;
      tx_start    <= 1'b0;
      tx_lane_vld <= 1'b0;
      // width only moves between flits
      if (!busy) begin
        act_mode <= sel_mode;
        act_base <= sel_base;
      end
      if (take) begin
        flit_q      <= tx_flit;
        tx_lanes    <= place_slice(get_slice(tx_flit, sel_mode, '0), sel_mode, sel_base);
        tx_start    <= 1'b1;
        tx_lane_vld <= 1'b1;
        cnt         <= CNT_W'(1);
        busy        <= 1'b1;
      end else if (busy) begin
        tx_lanes    <= place_slice(get_slice(flit_q, act_mode, cnt), act_mode, act_base);
        tx_lane_vld <= 1'b1;
        cnt         <= cnt + CNT_W'(1);
        if (cnt == xfer_last(act_mode)) busy <= 1'b0;
      end
    end
  end

  assert_start_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    take |=> (tx_start && tx_lane_vld));
  assert_burst_continues_R1: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> tx_lane_vld);
  assert_width_held_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (act_mode == $past(act_mode)));
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_mode == WM_IDLE && !busy) |=> !tx_lane_vld);
endmodule

// File: rtl/flm_rx_train.sv
module flm_rx_train
  import flm_pkg::*;
#(
  parameter logic [LANES-1:0] TRAIN_PAT  = 20'h3A5C1,
  parameter int               TRAIN_REPS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_train,
  input  logic             rx_valid,
  input  logic             rx_start,
  input  logic [LANES-1:0] rx_lanes,
  output logic [LANES-1:0] pol_q,
  output logic             rev_q
);
  localparam int SW = $clog2(TRAIN_REPS + 1);

  logic             phase;
  logic [LANES-1:0] cand_pol, last_pol;
  logic             last_rev;
  logic [SW-1:0]    streak;
  logic [LANES-1:0] fixed_w;
  logic             hit_dir, hit_rev, hit, agree;

  assign fixed_w = rx_lanes ^ cand_pol;
  assign hit_dir = (fixed_w == TRAIN_PAT);
  assign hit_rev = (flip_lanes(fixed_w) == TRAIN_PAT);
  assign hit     = hit_dir || hit_rev;
  assign agree   = (streak == '0) || ((last_pol == cand_pol) && (last_rev == hit_rev));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      cand_pol <= '0;
      last_pol <= '0;
      last_rev <= 1'b0;
      streak   <= '0;
      pol_q    <= '0;
      rev_q    <= 1'b0;
    end else if (!rx_train) begin
      phase  <= 1'b0;
      streak <= '0;
    end else if (rx_valid) begin
      if (rx_start) begin
        cand_pol <= rx_lanes;  // reference word is all zeros on the wire
        phase    <= 1'b1;
      end else if (phase) begin
        phase <= 1'b0;
        if (hit) begin
          last_pol <= cand_pol;
          last_rev <= hit_rev;
          if (agree && streak == SW'(TRAIN_REPS - 1)) begin
            pol_q  <= cand_pol;
            rev_q  <= hit_rev;
            streak <= '0;
          end else begin
            streak <= agree ? streak + SW'(1) : SW'(1);
          end
        end else begin
          streak <= '0;
        end
      end
    end
  end

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_train |=> ($stable(pol_q) && $stable(rev_q)));
  assert_commit_in_training_R7: assert property (@(posedge clk) disable iff (rst)
    (pol_q != $past(pol_q) || rev_q != $past(rev_q)) |-> $past(rx_train && rx_valid && !rx_start));
endmodule

// File: rtl/flm_rx_asm.sv
module flm_rx_asm
  import flm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wmode_e            mode,
  input  logic [1:0]        base,
  input  logic              dvalid,
  input  logic              rx_start,
  input  logic [LANES-1:0]  word,
  output logic [FLIT_W-1:0] rx_flit,
  output logic              rx_flit_vld
);
  wmode_e            mode_prev;
  logic              inflight;
  logic [CNT_W-1:0]  k;
  logic [FLIT_W-1:0] asm_q, asm_next;
  logic [CNT_W-1:0]  idx;
  logic              accept;

  assign idx      = rx_start ? '0 : k;
  assign accept   = dvalid && (mode != WM_IDLE) &&
                    (rx_start || (inflight && mode == mode_prev));
  assign asm_next = put_slice(rx_start ? '0 : asm_q, take_slice(word, mode, base), mode, idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_prev   <= WM_IDLE;
      inflight    <= 1'b0;
      k           <= '0;
      asm_q       <= '0;
      rx_flit     <= '0;
      rx_flit_vld <= 1'b0;
    end else begin
      rx_flit_vld <= 1'b0;
      mode_prev   <= mode;
      if (accept) begin
        asm_q <= asm_next;
        if (idx == xfer_last(mode)) begin
          rx_flit     <= asm_next;
          rx_flit_vld <= 1'b1;
          inflight    <= 1'b0;
          k           <= '0;
        end else begin
          inflight <= 1'b1;
          k        <= idx + CNT_W'(1);
        end
      end else if (mode != mode_prev) begin
        inflight <= 1'b0;  // width moved: drop partial flit
        k        <= '0;
      end
    end
  end

  assert_vld_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rx_flit_vld |=> !rx_flit_vld);
  assert_discard_on_change_R6: assert property (@(posedge clk) disable iff (rst)
    ((mode != mode_prev) && !(dvalid && rx_start)) |=> !inflight);
endmodule

// File: rtl/flit_lane_mapper.sv
module flit_lane_mapper
  import flm_pkg::*;
#(
  parameter logic [19:0] TRAIN_PAT  = 20'h3A5C1,
  parameter int          TRAIN_REPS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  quad_ok,
  input  logic [79:0] tx_flit,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic [19:0] tx_lanes,
  output logic        tx_start,
  output logic        tx_lane_vld,
  input  logic [19:0] rx_lanes,
  input  logic        rx_valid,
  input  logic        rx_start,
  input  logic        rx_train,
  output logic [79:0] rx_flit,
  output logic        rx_flit_vld
);
  wmode_e           sel_mode, act_mode, mode_d;
  logic [1:0]       sel_base, act_base, base_d;
  logic [LANES-1:0] pol_q, rx_unpol, rx_logical;
  logic             rev_q;

  flm_width_sel u_sel (
    .quad_ok (quad_ok),
    .mode    (sel_mode),
    .base    (sel_base)
  );

  flm_tx_serdes u_tx (
    .clk         (clk),
    .rst         (rst),
    .sel_mode    (sel_mode),
    .sel_base    (sel_base),
    .tx_flit     (tx_flit),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_lanes    (tx_lanes),
    .tx_start    (tx_start),
    .tx_lane_vld (tx_lane_vld),
    .act_mode    (act_mode),
    .act_base    (act_base)
  );

  flm_rx_train #(
    .TRAIN_PAT  (TRAIN_PAT),
    .TRAIN_REPS (TRAIN_REPS)
  ) u_train (
    .clk      (clk),
    .rst      (rst),
    .rx_train (rx_train),
    .rx_valid (rx_valid),
    .rx_start (rx_start),
    .rx_lanes (rx_lanes),
    .pol_q    (pol_q),
    .rev_q    (rev_q)
  );

  // receive side follows the agreed width one cycle behind the send side,
  // matching the send-side output register
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_d <= WM_IDLE;
      base_d <= 2'd0;
    end else begin
      mode_d <= act_mode;
      base_d <= act_base;
    end
  end

  assign rx_unpol   = rx_lanes ^ pol_q;
  assign rx_logical = rev_q ? flip_lanes(rx_unpol) : rx_unpol;

  flm_rx_asm u_asm (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode_d),
    .base        (base_d),
    .dvalid      (rx_valid && !rx_train),
    .rx_start    (rx_start),
    .word        (rx_logical),
    .rx_flit     (rx_flit),
    .rx_flit_vld (rx_flit_vld)
  );
endmodule

// File: tb/flit_lane_mapper_tb.sv
module flit_lane_mapper_tb;
  localparam logic [19:0] PAT  = 20'h3A5C1;
  localparam int          REPS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  quad_ok = 4'hF;
  logic [79:0] tx_flit = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_start, tx_lane_vld, rx_flit_vld;
  logic [19:0] tx_lanes;
  logic [19:0] rx_lanes = '0;
  logic        rx_valid = 1'b0, rx_start = 1'b0, rx_train = 1'b0;
  logic [79:0] rx_flit;

  int total = 0;
  int bad   = 0;
  logic [20:0] txq[$];
  string       txtag[$];
  logic [79:0] rxq[$];
  string       rxtag[$];

  always #2 clk = ~clk;

  flit_lane_mapper #(.TRAIN_PAT(PAT), .TRAIN_REPS(REPS)) u_dut (
    .clk(clk), .rst(rst), .quad_ok(quad_ok),
    .tx_flit(tx_flit), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_lanes(tx_lanes), .tx_start(tx_start), .tx_lane_vld(tx_lane_vld),
    .rx_lanes(rx_lanes), .rx_valid(rx_valid), .rx_start(rx_start), .rx_train(rx_train),
    .rx_flit(rx_flit), .rx_flit_vld(rx_flit_vld)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bw(input logic [3:0] q);
    if (&q) return 20;
    if (q[0] && q[1]) return 10;
    if (q[2] && q[3]) return 10;
    if (q != 4'd0) return 5;
    return 0;
  endfunction

  function automatic int bb(input logic [3:0] q);
    if (&q) return 0;
    if (q[0] && q[1]) return 0;
    if (q[2] && q[3]) return 2;
    for (int i = 0; i < 4; i++) if (q[i]) return i;
    return 0;
  endfunction

  function automatic logic [19:0] lword(input logic [79:0] f, input int k, input logic [3:0] q);
    logic [19:0] r;
    int w;
    int b;
    r = '0;
    w = bw(q);
    b = bb(q);
    for (int j = 0; j < w; j++) r[b*5+j] = f[k*w+j];
    return r;
  endfunction

  function automatic logic [19:0] wire_w(input logic [19:0] l, input bit rv, input logic [19:0] inv);
    logic [19:0] p;
    for (int i = 0; i < 20; i++) p[i] = (rv ? l[19-i] : l[i]) ^ inv[i];
    return p;
  endfunction

  function automatic logic [79:0] rnd_flit();
    logic [79:0] f;
    f[31:0]  = $urandom();
    f[63:32] = $urandom();
    f[79:64] = 16'($urandom());
    return f;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin : mon
    logic [20:0] e;
    logic [79:0] ef;
    string t;
    if (!rst) begin
      if (tx_lane_vld) begin
        if (txq.size() == 0) chk(1'b0, "R2 unexpected tx word", {59'd0, tx_start, tx_lanes}, '0);
        else begin
          e = txq.pop_front();
          t = txtag.pop_front();
          chk({tx_start, tx_lanes} == e, t, {59'd0, tx_start, tx_lanes}, {59'd0, e});
        end
      end
      if (rx_flit_vld) begin
        if (rxq.size() == 0) chk(1'b0, "R6 unexpected rx flit", rx_flit, '0);
        else begin
          ef = rxq.pop_front();
          t  = rxtag.pop_front();
          chk(rx_flit == ef, t, rx_flit, ef);
        end
      end
    end
  end

  task automatic send_tx(input logic [79:0] f, input string tag);
    @(negedge clk);
    tx_flit  = f;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    for (int k = 0; k < 80 / bw(quad_ok); k++) begin
      txq.push_back({k == 0, lword(f, k, quad_ok)});
      txtag.push_back(tag);
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic rx_slices(input logic [79:0] f, input int from, input int cnt, input bit st,
                           input bit rv, input logic [19:0] inv, input bit gap);
    for (int k = from; k < from + cnt; k++) begin
      if (gap && k == from + 1) begin
        @(negedge clk);
        rx_valid = 1'b0;
        rx_start = 1'b1;
        rx_lanes = 20'($urandom());
      end
      @(negedge clk);
      rx_valid = 1'b1;
      rx_start = st && (k == from);
      rx_lanes = wire_w(lword(f, k, quad_ok), rv, inv);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_start = 1'b0;
    rx_lanes = '0;
  endtask

  task automatic send_rx(input logic [79:0] f, input bit rv, input logic [19:0] inv,
                         input bit gap, input string tag);
    rxq.push_back(f);
    rxtag.push_back(tag);
    rx_slices(f, 0, 80 / bw(quad_ok), 1'b1, rv, inv, gap);
  endtask

  task automatic train(input bit rv, input logic [19:0] inv, input int pairs, input bit good);
    for (int i = 0; i < pairs; i++) begin
      @(negedge clk);
      rx_train = 1'b1;
      rx_valid = 1'b1;
      rx_start = 1'b1;
      rx_lanes = wire_w(20'd0, rv, inv);
      @(negedge clk);
      rx_start = 1'b0;
      rx_lanes = wire_w(good ? PAT : (PAT ^ 20'h00100), rv, inv);
    end
    @(negedge clk);
    rx_train = 1'b0;
    rx_valid = 1'b0;
    rx_lanes = '0;
  endtask

  task automatic set_quads(input logic [3:0] q);
    @(negedge clk);
    quad_ok = q;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_all();
    logic [19:0] inv_a;
    logic [19:0] inv_b;
    inv_a = 20'h8_1C05;
    inv_b = 20'h2_0410;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R2, R5)
    chk(!tx_lane_vld, "R2 reset no tx word", {79'd0, tx_lane_vld}, '0);
    chk(!rx_flit_vld, "R5 reset no rx flit", {79'd0, rx_flit_vld}, '0);
    repeat (2) @(negedge clk);

    // R1 / R2: full width
    send_tx(rnd_flit(), "R1 full width word");
    send_tx(80'h0123_4567_89AB_CDEF_FEDC, "R1 full width word");
    repeat (6) @(negedge clk);

    // R3: each reduced width
    set_quads(4'b1011);
    send_tx(rnd_flit(), "R3 half low lanes");
    repeat (10) @(negedge clk);
    set_quads(4'b1100);
    send_tx(rnd_flit(), "R3 half high lanes");
    repeat (10) @(negedge clk);
    set_quads(4'b0100);
    send_tx(rnd_flit(), "R3 quarter lanes 10-14");
    repeat (18) @(negedge clk);
    set_quads(4'b1010);
    send_tx(rnd_flit(), "R3 quarter lanes 5-9");
    repeat (18) @(negedge clk);

    // R3: idle
    set_quads(4'b0000);
    tx_flit  = rnd_flit();
    tx_valid = 1'b1;
    chk(!tx_ready, "R3 idle not ready", {79'd0, tx_ready}, '0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!tx_lane_vld && tx_lanes == 20'd0, "R3 idle sends nothing", {59'd0, tx_lane_vld, tx_lanes}, '0);
    end
    tx_valid = 1'b0;

    // R4: width change in the middle of a flit
    set_quads(4'hF);
    send_tx(rnd_flit(), "R4 flit keeps start width");
    quad_ok = 4'b0011;
    send_tx(rnd_flit(), "R4 next flit new width");
    repeat (12) @(negedge clk);

    // R5: receive with default wiring
    set_quads(4'hF);
    send_rx(rnd_flit(), 1'b0, 20'd0, 1'b0, "R5 rx full default wiring");
    repeat (3) @(negedge clk);

    // R7 / R8: train for reversed, inverted wiring
    train(1'b1, inv_a, REPS, 1'b1);
    send_rx(rnd_flit(), 1'b1, inv_a, 1'b0, "R8 rx full reversed inverted");
    set_quads(4'b0011);
    send_rx(rnd_flit(), 1'b1, inv_a, 1'b0, "R8 rx half reversed inverted");
    set_quads(4'b0100);
    send_rx(rnd_flit(), 1'b1, inv_a, 1'b0, "R8 rx quarter reversed inverted");
    set_quads(4'hF);

    // R9: short run and bad runs leave the settings alone
    train(1'b0, inv_b, REPS - 1, 1'b1);
    send_rx(rnd_flit(), 1'b1, inv_a, 1'b0, "R9 short training no change");
    train(1'b0, inv_b, REPS + 1, 1'b0);
    send_rx(rnd_flit(), 1'b1, inv_a, 1'b0, "R9 bad pattern no change");

    // R10: idle receive cycles inside a flit
    send_rx(rnd_flit(), 1'b1, inv_a, 1'b1, "R10 invalid cycles ignored");

    // R6: new start drops partial flit
    rx_slices(rnd_flit(), 0, 2, 1'b1, 1'b1, inv_a, 1'b0);
    send_rx(rnd_flit(), 1'b1, inv_a, 1'b0, "R6 restart keeps only new flit");
    // R6: width change drops partial flit
    set_quads(4'b0001);
    rx_slices(rnd_flit(), 0, 12, 1'b1, 1'b1, inv_a, 1'b0);
    set_quads(4'hF);
    rx_slices(rnd_flit(), 0, 4, 1'b0, 1'b1, inv_a, 1'b0);
    repeat (3) @(negedge clk);
    chk(rxq.size() == 0, "R6 no flit after width change", 80'(rxq.size()), '0);
    send_rx(rnd_flit(), 1'b1, inv_a, 1'b0, "R6 clean flit after change");

    // R7: retrain to a different wiring
    train(1'b0, inv_b, REPS, 1'b1);
    send_rx(rnd_flit(), 1'b0, inv_b, 1'b0, "R7 retrained direct order");

    repeat (30) @(negedge clk);
    chk(txq.size() == 0, "R1 all tx words seen", 80'(txq.size()), '0);
    chk(rxq.size() == 0, "R5 all rx flits seen", 80'(rxq.size()), '0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", '0, '0);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule